// File: doc/BRIEF.md
# Interrupt Class Priority Arbiter

This block chooses which pending interrupt the processor takes next. Requests arrive in four classes with a fixed ranking: exceptions, event interrupts, software interrupts and traps. Exception requests and trap strobes are taken whatever the current execution priority. Event and software requests must have a level strictly above the 4-bit execution priority that the core supplies from its status word.

Event sources set pending flags held inside the block. Each event source has a level that software writes through a simple write port. Software interrupts are a bank of request bits that software writes as a whole. Each bit has a fixed level equal to its index plus one. A trap strobe carries a trap number, which is held until the trap is taken.

Every cycle the block evaluates all requests and produces a registered decision: a one-cycle take pulse, the class code and a vector index within that class. When an event wins, a one-hot acknowledge is raised in the same cycle as the take pulse, and that event's pending flag is cleared.

Top module: `intr_class_arb`

## Requirements
- R1: After reset `take_o` and `evt_ack_o` are 0, no event is pending, every event level is 0, all software request bits are 0 and no trap is held.
- R2: If any `exc_req_i` bit is 1 in a cycle, the next cycle shows `take_o`=1, `cls_o`=0 and `vec_o` equal to the lowest set bit's index, whatever `cur_pri_i` holds.
- R3: A pending event is eligible only when its level is strictly greater than `cur_pri_i`. A flag set by `evt_set_i` becomes pending, and is considered, from the following cycle.
- R4: Among eligible events the highest level wins, and a tie goes to the lower index. The result shows `cls_o`=1 and `vec_o` = event index.
- R5: Software bit i has fixed level i+1 and is eligible only when i+1 > `cur_pri_i`. The highest eligible level wins, shown as `cls_o`=2 with `vec_o`=i.
- R6: The classes rank exception (0) above event (1) above software (2) above trap (3). Only the highest ranked class with an eligible request is taken, and at most one take happens per cycle.
- R7: A trap is taken with `cls_o`=3 and `vec_o`=trap number, with no priority gating. A strobe that is not taken at once is held until it is taken. A new strobe replaces the held number. A strobe is taken in the next cycle when nothing ranked higher is eligible.
- R8: When an event is taken, `evt_ack_o` is one-hot at that event's index in the same cycle as `take_o`, and its pending flag is cleared. A set arriving in the cycle the flag is cleared keeps it pending.
- R9: Taking a software interrupt does not clear its request bit. Only a write through `swi_wr_en_i` changes the bits.
- R10: An event at level 0 is never taken, for any `cur_pri_i`.
- R11: `pri_wr_en_i` writes `pri_wr_lvl_i` as the level of event `pri_wr_idx_i`. The new level takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | N_EXC | Exception request lines |
| evt_set_i | input | N_EVT | Event set pulses |
| pri_wr_en_i | input | 1 | Event level write enable |
| pri_wr_idx_i | input | clog2(N_EVT) | Event index to write |
| pri_wr_lvl_i | input | PRI_W | Level to write |
| swi_wr_en_i | input | 1 | Software request bank write enable |
| swi_wr_data_i | input | N_SWI | New software request bits |
| trap_stb_i | input | 1 | Trap instruction strobe |
| trap_num_i | input | TRAP_W | Trap number |
| cur_pri_i | input | PRI_W | Current execution priority |
| take_o | output | 1 | Take-interrupt pulse |
| cls_o | output | 2 | Class of the taken interrupt |
| vec_o | output | IDX_W | Index within the class |
| evt_ack_o | output | N_EVT | One-hot event acknowledge |

## Verification
Two pairs of functions can fall in the same cycle. In the first, an event is cleared by its own acknowledge while a new set pulse arrives for the same source. In the second, a trap strobe arrives while an exception or another trap is already held. Directed sequences set up both pairs: the same source is set again in the cycle it is taken, and a trap strobe is given while exceptions are active, followed by a second strobe. The random phase also produces both overlaps. The bench model judges them by the rules above: the re-set flag must be taken again, and the trap number taken must be the most recent one.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
  typedef enum logic [1:0] {
    CLS_EXC  = 2'd0,
    CLS_EVT  = 2'd1,
    CLS_SWI  = 2'd2,
    CLS_TRAP = 2'd3
  } intr_cls_e;
endpackage

// File: rtl/intr_lvl_pick.sv
// Picks the eligible source with the highest level; the lower index wins a tie.
module intr_lvl_pick #(
  parameter int N  = 8,
  parameter int LW = 4,
  parameter int IW = 3
) (
  input  logic [N-1:0]    elig_i,
  input  logic [N*LW-1:0] lvls_i,
  output logic            found_o,
  output logic [IW-1:0]   idx_o,
  output logic [LW-1:0]   lvl_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!found_o || (lvls_i[i*LW +: LW] > lvl_o))) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        lvl_o   = lvls_i[i*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/intr_evt_store.sv
// Per-source event pending flag and software-written level.
module intr_evt_store #(
  parameter int N  = 8,
  parameter int LW = 4,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  clr_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [LW-1:0] wr_lvl_i,
  output logic [N-1:0]  pend_o,
  output logic [N*LW-1:0] lvls_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic          pend_q, pend_d;
    logic [LW-1:0] lvl_q;
    logic          lvl_en;

    always_comb begin
      lvl_en = wr_en_i && (wr_idx_i == IW'(g));
      pend_d = set_i[g] | (pend_q & ~clr_i[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        lvl_q  <= '0;
      end else begin
        pend_q <= pend_d;
        if (lvl_en) lvl_q <= wr_lvl_i;
      end
    end

    assign pend_o[g]             = pend_q;
    assign lvls_o[g*LW +: LW]    = lvl_q;
  end
endmodule

// File: rtl/intr_class_arb.sv
module intr_class_arb
  import intr_arb_pkg::*;
#(
  parameter int N_EXC  = 4,
  parameter int N_EVT  = 8,
  parameter int N_SWI  = 7,
  parameter int PRI_W  = 4,
  parameter int TRAP_W = 4,
  localparam int EXC_IW = (N_EXC > 1) ? $clog2(N_EXC) : 1,
  localparam int EVT_IW = (N_EVT > 1) ? $clog2(N_EVT) : 1,
  localparam int SWI_IW = (N_SWI > 1) ? $clog2(N_SWI) : 1,
  localparam int MAX_A  = (EXC_IW > EVT_IW) ? EXC_IW : EVT_IW,
  localparam int MAX_B  = (SWI_IW > TRAP_W) ? SWI_IW : TRAP_W,
  localparam int IDX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXC-1:0]  exc_req_i,
  input  logic [N_EVT-1:0]  evt_set_i,
  input  logic              pri_wr_en_i,
  input  logic [EVT_IW-1:0] pri_wr_idx_i,
  input  logic [PRI_W-1:0]  pri_wr_lvl_i,
  input  logic              swi_wr_en_i,
  input  logic [N_SWI-1:0]  swi_wr_data_i,
  input  logic              trap_stb_i,
  input  logic [TRAP_W-1:0] trap_num_i,
  input  logic [PRI_W-1:0]  cur_pri_i,
  output logic              take_o,
  output logic [1:0]        cls_o,
  output logic [IDX_W-1:0]  vec_o,
  output logic [N_EVT-1:0]  evt_ack_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [N_EVT-1:0]       evt_pend, evt_elig, ack_d;
  logic [N_EVT*PRI_W-1:0] evt_lvls;
  logic [N_SWI*PRI_W-1:0] swi_lvls;
  logic [N_SWI-1:0]       swi_q, swi_elig;
  logic                   evt_found, swi_found;
  logic [EVT_IW-1:0]      evt_idx;
  logic [SWI_IW-1:0]      swi_idx;
  logic [PRI_W-1:0]       evt_lvl, swi_lvl;

  intr_evt_store #(.N(N_EVT), .LW(PRI_W), .IW(EVT_IW)) evt_store_i (
    .clk(clk), .rst_n(rst_s_q), .set_i(evt_set_i), .clr_i(ack_d),
    .wr_en_i(pri_wr_en_i), .wr_idx_i(pri_wr_idx_i), .wr_lvl_i(pri_wr_lvl_i),
    .pend_o(evt_pend), .lvls_o(evt_lvls)
  );

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt_el
    assign evt_elig[g] = evt_pend[g] && (evt_lvls[g*PRI_W +: PRI_W] > cur_pri_i);
  end

  for (genvar g = 0; g < N_SWI; g++) begin : g_swi_el
    assign swi_lvls[g*PRI_W +: PRI_W] = PRI_W'(g + 1);
    assign swi_elig[g] = swi_q[g] && (PRI_W'(g + 1) > cur_pri_i);
  end

  intr_lvl_pick #(.N(N_EVT), .LW(PRI_W), .IW(EVT_IW)) evt_pick_i (
    .elig_i(evt_elig), .lvls_i(evt_lvls),
    .found_o(evt_found), .idx_o(evt_idx), .lvl_o(evt_lvl)
  );

  intr_lvl_pick #(.N(N_SWI), .LW(PRI_W), .IW(SWI_IW)) swi_pick_i (
    .elig_i(swi_elig), .lvls_i(swi_lvls),
    .found_o(swi_found), .idx_o(swi_idx), .lvl_o(swi_lvl)
  );

  // lowest-index exception
  logic              exc_any;
  logic [EXC_IW-1:0] exc_idx;
  always_comb begin
    exc_any = |exc_req_i;
    exc_idx = '0;
    for (int i = N_EXC - 1; i >= 0; i--) begin
      if (exc_req_i[i]) exc_idx = EXC_IW'(i);
    end
  end

  // trap holding and class decision
  logic              trap_pend_q, trap_pend_d, trap_eff;
  logic [TRAP_W-1:0] trap_num_q, trap_num_d, trap_num_eff;
  logic              take_d;
  intr_cls_e         cls_d;
  logic [IDX_W-1:0]  vec_d;
  logic [N_SWI-1:0]  swi_d;
  logic              swi_en;

  always_comb begin
    trap_eff     = trap_stb_i | trap_pend_q;
    trap_num_eff = trap_stb_i ? trap_num_i : trap_num_q;
    take_d       = 1'b1;
    cls_d        = CLS_TRAP;
    vec_d        = IDX_W'(trap_num_eff);
    ack_d        = '0;
    if (exc_any) begin
      cls_d = CLS_EXC;
      vec_d = IDX_W'(exc_idx);
    end else if (evt_found) begin
      cls_d          = CLS_EVT;
      vec_d          = IDX_W'(evt_idx);
      ack_d[evt_idx] = 1'b1;
    end else if (swi_found) begin
      cls_d = CLS_SWI;
      vec_d = IDX_W'(swi_idx);
    end else if (!trap_eff) begin
      take_d = 1'b0;
      vec_d  = '0;
    end
    trap_pend_d = trap_eff && !(take_d && (cls_d == CLS_TRAP));
    trap_num_d  = trap_num_eff;
    swi_en      = swi_wr_en_i;
    swi_d       = swi_wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      take_o      <= 1'b0;
      cls_o       <= 2'd0;
      vec_o       <= '0;
      evt_ack_o   <= '0;
      swi_q       <= '0;
      trap_pend_q <= 1'b0;
      trap_num_q  <= '0;
    end else begin
      take_o      <= take_d;
      cls_o       <= cls_d;
      vec_o       <= vec_d;
      evt_ack_o   <= ack_d;
      trap_pend_q <= trap_pend_d;
      trap_num_q  <= trap_num_d;
      if (swi_en) swi_q <= swi_d;
    end
  end
endmodule

// File: rtl/intr_class_arb_chk.sv
module intr_class_arb_chk #(
  parameter int N_EXC  = 4,
  parameter int N_EVT  = 8,
  parameter int PRI_W  = 4,
  parameter int IDX_W  = 4,
  parameter int EVT_IW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EXC-1:0] exc_req_i,
  input logic [PRI_W-1:0] cur_pri_i,
  input logic             take_o,
  input logic [1:0]       cls_o,
  input logic [IDX_W-1:0] vec_o,
  input logic [N_EVT-1:0] evt_ack_o
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt_ack_o)); // R8

  AST_ACK_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ack_o != '0) |-> (take_o && cls_o == 2'd1)); // R8

  AST_ACK_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && cls_o == 2'd1) |-> evt_ack_o[vec_o[EVT_IW-1:0]]); // R8

  AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i != '0) |=> (take_o && cls_o == 2'd0)); // R2

  AST_SWI_ABOVE_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && cls_o == 2'd2) |-> ((int'(vec_o) + 1) > int'($past(cur_pri_i)))); // R5
endmodule

bind intr_class_arb intr_class_arb_chk #(
  .N_EXC(N_EXC), .N_EVT(N_EVT), .PRI_W(PRI_W), .IDX_W(IDX_W), .EVT_IW(EVT_IW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req_i), .cur_pri_i(cur_pri_i),
  .take_o(take_o), .cls_o(cls_o), .vec_o(vec_o), .evt_ack_o(evt_ack_o)
);

// File: tb/intr_class_arb_tb_top.sv
module intr_class_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_EXC = 4, N_EVT = 8, N_SWI = 7, PRI_W = 4, TRAP_W = 4;
  localparam int IDX_W = 4, EVT_IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N_EXC-1:0]  exc_req;
  logic [N_EVT-1:0]  evt_set;
  logic              pri_wr_en;
  logic [EVT_IW-1:0] pri_wr_idx;
  logic [PRI_W-1:0]  pri_wr_lvl;
  logic              swi_wr_en;
  logic [N_SWI-1:0]  swi_wr_data;
  logic              trap_stb;
  logic [TRAP_W-1:0] trap_num;
  logic [PRI_W-1:0]  cur_pri;
  logic              take;
  logic [1:0]        cls;
  logic [IDX_W-1:0]  vec;
  logic [N_EVT-1:0]  evt_ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_class_arb dut_i (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .evt_set_i(evt_set),
    .pri_wr_en_i(pri_wr_en), .pri_wr_idx_i(pri_wr_idx), .pri_wr_lvl_i(pri_wr_lvl),
    .swi_wr_en_i(swi_wr_en), .swi_wr_data_i(swi_wr_data),
    .trap_stb_i(trap_stb), .trap_num_i(trap_num), .cur_pri_i(cur_pri),
    .take_o(take), .cls_o(cls), .vec_o(vec), .evt_ack_o(evt_ack)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  bit [N_EVT-1:0] m_pend;
  int             m_lvl [N_EVT];
  bit [N_SWI-1:0] m_swi;
  bit             m_tpend;
  int             m_tnum;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // computes the expected decision for the present inputs and advances the model
  task automatic cycle(input string tag);
    bit e_take = 1'b0;
    int e_cls = 0, e_vec = 0, best = -1;
    bit [N_EVT-1:0] e_ack = '0;
    bit t_eff = trap_stb || m_tpend;
    int t_num = trap_stb ? int'(trap_num) : m_tnum;
    for (int i = N_EXC - 1; i >= 0; i--)
      if (exc_req[i]) begin e_take = 1; e_cls = 0; e_vec = i; end
    if (!e_take) begin
      for (int i = 0; i < N_EVT; i++)
        if (m_pend[i] && m_lvl[i] > int'(cur_pri) && m_lvl[i] > best) begin
          best = m_lvl[i]; e_take = 1; e_cls = 1; e_vec = i;
        end
      if (e_take) e_ack[e_vec] = 1'b1;
    end
    if (!e_take)
      for (int i = 0; i < N_SWI; i++)
        if (m_swi[i] && (i + 1) > int'(cur_pri)) begin e_take = 1; e_cls = 2; e_vec = i; end
    if (!e_take && t_eff) begin e_take = 1; e_cls = 3; e_vec = t_num; end
    // advance model
    m_pend = (m_pend & ~e_ack) | evt_set;
    if (pri_wr_en) m_lvl[pri_wr_idx] = int'(pri_wr_lvl);
    if (swi_wr_en) m_swi = swi_wr_data;
    m_tpend = t_eff && !(e_take && e_cls == 3);
    m_tnum  = t_num;
    @(negedge clk);
    chk(take == e_take, tag, "take", int'(take), int'(e_take));
    if (e_take) begin
      chk(int'(cls) == e_cls, tag, "class", int'(cls), e_cls);
      chk(int'(vec) == e_vec, tag, "vector", int'(vec), e_vec);
    end
    chk(evt_ack == e_ack, tag, "ack", int'(evt_ack), int'(e_ack));
    evt_set = '0; pri_wr_en = 0; swi_wr_en = 0; trap_stb = 0;
  endtask

  task automatic wr_lvl(input int idx, input int lvl);
    pri_wr_en = 1; pri_wr_idx = EVT_IW'(idx); pri_wr_lvl = PRI_W'(lvl);
    cycle("R11");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst_n = 0; exc_req = '0; evt_set = '0; pri_wr_en = 0; pri_wr_idx = '0;
    pri_wr_lvl = '0; swi_wr_en = 0; swi_wr_data = '0; trap_stb = 0;
    trap_num = '0; cur_pri = '0;
    m_pend = '0; m_swi = '0; m_tpend = 0; m_tnum = 0;
    for (int i = 0; i < N_EVT; i++) m_lvl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: idle after reset
    chk(take == 1'b0, "R1", "take after reset", int'(take), 0);
    chk(evt_ack == '0, "R1", "ack after reset", int'(evt_ack), 0);
    cycle("R1");

    // R10: level-0 event never taken even at lowest execution priority
    evt_set = 8'h08; cur_pri = 0; cycle("R10");
    cycle("R10"); cycle("R10");

    // R3/R11: level 5 at priority 5 not taken, at 4 taken with ack (R8)
    cur_pri = 5; wr_lvl(3, 5);
    cycle("R3");
    cur_pri = 4; cycle("R3");
    cycle("R8");

    // R4: highest level wins, tie to lower index
    cur_pri = 15;
    wr_lvl(1, 6); wr_lvl(6, 6); wr_lvl(2, 4);
    evt_set = 8'h46 | 8'h00; cycle("R4");
    cur_pri = 0; cycle("R4"); cycle("R4"); cycle("R4"); cycle("R4");

    // R5/R9: fixed software levels, bit not cleared by take
    cur_pri = 4; swi_wr_en = 1; swi_wr_data = 7'b0010100; cycle("R5");
    cycle("R9"); cycle("R9");
    cur_pri = 5; cycle("R5");
    cur_pri = 2; cycle("R5");
    swi_wr_en = 1; swi_wr_data = '0; cycle("R9");
    cycle("R9");

    // R2/R6/R7: exceptions over everything, trap held then taken
    cur_pri = 15; wr_lvl(5, 2); evt_set = 8'h20; cycle("R6");
    swi_wr_en = 1; swi_wr_data = 7'b1000001;
    exc_req = 4'b0110; trap_stb = 1; trap_num = 9; cycle("R2");
    cycle("R2");
    trap_stb = 1; trap_num = 12; cycle("R7");
    exc_req = '0; cur_pri = 1; cycle("R6");
    cycle("R6");
    swi_wr_en = 1; swi_wr_data = '0; cycle("R6");
    cycle("R7");
    cur_pri = 15; trap_stb = 1; trap_num = 3; cycle("R7");
    cycle("R7");

    // R8: set in the cycle of its own acknowledge keeps it pending
    cur_pri = 0; evt_set = 8'h20; cycle("R8");
    evt_set = 8'h20; cycle("R8");
    cycle("R8"); cycle("R8");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      cur_pri = PRI_W'($urandom_range(0, 15));
      exc_req = ($urandom_range(0, 15) == 0) ? N_EXC'($urandom) : '0;
      evt_set = N_EVT'($urandom) & N_EVT'($urandom) & N_EVT'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        pri_wr_en = 1; pri_wr_idx = EVT_IW'($urandom); pri_wr_lvl = PRI_W'($urandom);
      end
      if ($urandom_range(0, 7) == 0) begin
        swi_wr_en = 1; swi_wr_data = N_SWI'($urandom) & N_SWI'($urandom);
      end
      if ($urandom_range(0, 7) == 0) begin
        trap_stb = 1; trap_num = TRAP_W'($urandom);
      end
      cycle("R6");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule